// File: doc/BRIEF.md
# Shading Table Fetch Scheduler

This block decides when the lens shading correction stage must pull table lines from memory. Every table line holds four gain bytes per paxel across the image row. An optional second table, at its own base address, holds four offset bytes per paxel in the same layout. The block follows frame timing from a single-cycle vertical sync pulse and a single-cycle line-done strobe. It keeps the fetches ahead of the paxel row being corrected: two lines are fetched when the block is switched on, one line at each vertical sync, one line each time a full paxel row of image lines has gone by, and two lines when the last paxel row starts. Those last two lines are the first lines of the next frame.

Each table line is split into 32-byte read bursts at increasing addresses. The bursts go out on a request/grant handshake. A programmable gap counter spreads the bursts over time so that the table traffic does not arrive as a peak. An underrun pulse reports a paxel-row window that closed before the fetches queued for it had finished.

Top module: `shade_fetch_sched`

## Requirements
- R1: During reset, `req` and `underrun` are low.
- R2: In the cycle after `gain_en` rises, two table lines are queued. These are line 0 and then line 1. For each line, all gain bursts go out, followed by all offset bursts when `ofs_en` is 1.
- R3: A line has B = ceil(ceil(img_w / M) / 8) bursts. Burst b of table line L is read at base + (L*B + b)*32. The base is `gain_base` when `req_ofs` is 0 and `ofs_base` when `req_ofs` is 1.
- R4: When `ofs_en` is 0, no burst is issued with `req_ofs` = 1.
- R5: Size codes 0, 1, 2, 3 and 4 on `size_m` and `size_n` select 8, 16, 32, 64 and 128. Codes 5, 6 and 7 select 128.
- R6: `vsync` queues one table line. `line_done` has no effect until the first `vsync` after enable.
- R7: The image has P = ceil(img_h / N) paxel rows, and the table has P+1 lines. After every N `line_done` strobes of a frame, the next paxel row k begins. When 1 <= k < P-1, one line is queued. When k = P-1, two lines are queued. The table line index runs 0, 1, ..., P and then wraps to 0.
- R8: A request that is not granted holds `req` high and `req_addr` unchanged.
- R9: After a grant, `req` stays low for exactly `gap` cycles. With `gap` = 0, the next burst can be requested in the cycle right after the grant.
- R10: `underrun` pulses high for one cycle after a `vsync` or a paxel-row boundary that arrives while previously queued lines are still unfinished.
- R11: While `gain_en` is 0, all state is cleared. One cycle after `gain_en` falls, `req` is low. `vsync` and `line_done` have no effect while `gain_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low reset |
| gain_en | input | 1 | Enables the gain table fetch and the block as a whole |
| ofs_en | input | 1 | Also fetches the offset table |
| size_m | input | 3 | Paxel width code |
| size_n | input | 3 | Paxel height code |
| img_w | input | WW | Image width in pixels |
| img_h | input | HW | Image height in lines |
| gain_base | input | AW | Byte address of gain table line 0 |
| ofs_base | input | AW | Byte address of offset table line 0 |
| gap | input | GW | Idle cycles enforced after each grant |
| vsync | input | 1 | Frame start pulse |
| line_done | input | 1 | Pulse at the end of each image line |
| gnt | input | 1 | Grant for the current request |
| req | output | 1 | Burst read request |
| req_addr | output | AW | Byte address of the 32-byte burst |
| req_ofs | output | 1 | 1 when the burst reads the offset table |
| underrun | output | 1 | Pulse when a paxel-row window closes with fetches still pending |

## Verification
The assertions assume a few things about the inputs:
- The configuration inputs stay constant while `gain_en` is high.
- `vsync` and `line_done` are single-cycle pulses that never occur in the same cycle.
- The image spans at least three paxel rows.

The bench changes the configuration only while the block is disabled. It drives each strobe for exactly one cycle, on its own, and chooses image heights that give four or five paxel rows. Grants come back in the same cycle as the request, except in the stall test, where they are withheld.

// File: rtl/shade_fetch_sched.sv
module shade_fetch_sched #(
  parameter int AW = 32,
  parameter int WW = 14,
  parameter int HW = 14,
  parameter int GW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gain_en,
  input  logic          ofs_en,
  input  logic [2:0]    size_m,
  input  logic [2:0]    size_n,
  input  logic [WW-1:0] img_w,
  input  logic [HW-1:0] img_h,
  input  logic [AW-1:0] gain_base,
  input  logic [AW-1:0] ofs_base,
  input  logic [GW-1:0] gap,
  input  logic          vsync,
  input  logic          line_done,
  input  logic          gnt,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic          req_ofs,
  output logic          underrun
);

  logic [2:0] msh, nsh;
  logic [7:0] mmask, nmask;
  logic [WW:0] pax_x, bursts;
  logic [HW:0] rows;

  assign msh   = ((size_m > 3'd4) ? 3'd4 : size_m) + 3'd3;
  assign nsh   = ((size_n > 3'd4) ? 3'd4 : size_n) + 3'd3;
  assign mmask = (8'd1 << msh) - 8'd1;
  assign nmask = (8'd1 << nsh) - 8'd1;
  assign pax_x  = ({1'b0, img_w} + {{(WW-7){1'b0}}, mmask}) >> msh;
  assign bursts = (pax_x + (WW+1)'(7)) >> 3;
  assign rows   = ({1'b0, img_h} + {{(HW-7){1'b0}}, nmask}) >> nsh;

  logic          on, in_frame, sel;
  logic [6:0]    lcnt;
  logic [HW:0]   prow, lidx, nxt_row;
  logic [2:0]    pend, left;
  logic [AW-1:0] tbl_off;
  logic [WW:0]   bcnt;
  logic [GW-1:0] gap_cnt;
  logic [1:0]    add;
  logic          grant, last_b, line_end, live, ld, bnd;

  assign req      = on && (pend != 3'd0) && (gap_cnt == '0);
  assign req_ofs  = sel;
  assign req_addr = (sel ? ofs_base : gain_base) + tbl_off + AW'({bcnt, 5'b0});

  assign grant    = req && gnt;
  assign last_b   = (bcnt == bursts - (WW+1)'(1));
  assign line_end = grant && last_b && (sel || !ofs_en);
  assign left     = pend - {2'b0, line_end};
  assign live     = on && gain_en;
  assign ld       = live && in_frame && line_done && !vsync;
  assign bnd      = ld && (lcnt == nmask[6:0]);
  assign nxt_row  = prow + (HW+1)'(1);

  always_comb begin
    add = 2'd0;
    if (live && vsync)
      add = 2'd1;
    else if (bnd && (nxt_row < rows))
      add = (nxt_row == rows - (HW+1)'(1)) ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !gain_en) begin
      on <= 1'b0; in_frame <= 1'b0; sel <= 1'b0; underrun <= 1'b0;
      lcnt <= '0; prow <= '0; lidx <= '0; pend <= '0;
      tbl_off <= '0; bcnt <= '0; gap_cnt <= '0;
    end else if (!on) begin
      on   <= 1'b1;
      pend <= 3'd2;
    end else begin
      pend     <= left + {1'b0, add};
      underrun <= (add != 2'd0) && (left != 3'd0);
      if (vsync) begin
        in_frame <= 1'b1;
        lcnt     <= '0;
        prow     <= '0;
      end else if (ld) begin
        if (bnd) begin
          lcnt <= '0;
          prow <= nxt_row;
        end else begin
          lcnt <= lcnt + 7'd1;
        end
      end
      if (grant)
        gap_cnt <= gap;
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - GW'(1);
      if (grant) begin
        if (!last_b) begin
          bcnt <= bcnt + (WW+1)'(1);
        end else begin
          bcnt <= '0;
          if (!sel && ofs_en) begin
            sel <= 1'b1;
          end else begin
            sel <= 1'b0;
            if (lidx == rows) begin
              lidx    <= '0;
              tbl_off <= '0;
            end else begin
              lidx    <= lidx + (HW+1)'(1);
              tbl_off <= tbl_off + AW'({bursts, 5'b0});
            end
          end
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt && gain_en) |=> (req && $stable(req_addr))); // R8
  AST_GAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && gnt && gap != '0) |=> !req); // R9
  AST_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_en |=> (!req && !underrun)); // R11
  AST_NO_OFS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ofs_en) |-> !req_ofs); // R4
  AST_UNDER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(vsync || line_done)); // R10

endmodule

// File: tb/shade_fetch_sched_tb.sv
module shade_fetch_sched_tb;
  localparam int AW = 32, WW = 14, HW = 14, GW = 13;
  localparam logic [31:0] GB = 32'h0000_1000;
  localparam logic [31:0] OB = 32'h0008_0000;

  // {size_m, size_n, img_w, img_h, ofs_en, gap}
  localparam int NV = 5;
  localparam logic [47:0] VEC [NV] = '{
    {3'd0, 3'd0, 14'd64,   14'd32,  1'b1, 13'd0},
    {3'd1, 3'd1, 14'd300,  14'd64,  1'b0, 13'd3},
    {3'd7, 3'd2, 14'd260,  14'd100, 1'b1, 13'd2},
    {3'd4, 3'd5, 14'd1000, 14'd400, 1'b1, 13'd1},
    {3'd2, 3'd0, 14'd520,  14'd40,  1'b0, 13'd5}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, gain_en, ofs_en, vsync, line_done, gnt, req, req_ofs, underrun;
  logic [2:0] size_m, size_n;
  logic [WW-1:0] img_w;
  logic [HW-1:0] img_h;
  logic [AW-1:0] gain_base, ofs_base, req_addr;
  logic [GW-1:0] gap;
  logic auto_gnt;

  assign gnt = auto_gnt & req;

  shade_fetch_sched #(.AW(AW), .WW(WW), .HW(HW), .GW(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .gain_en(gain_en), .ofs_en(ofs_en),
    .size_m(size_m), .size_n(size_n), .img_w(img_w), .img_h(img_h),
    .gain_base(gain_base), .ofs_base(ofs_base), .gap(gap),
    .vsync(vsync), .line_done(line_done), .gnt(gnt),
    .req(req), .req_addr(req_addr), .req_ofs(req_ofs), .underrun(underrun));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] la [256];
  logic        lo [256];
  int          lt [256];
  int nlog = 0, nund = 0;
  always @(negedge clk) begin
    if (req && gnt && nlog < 256) begin
      la[nlog] = req_addr; lo[nlog] = req_ofs; lt[nlog] = cyc; nlog++;
    end
    if (underrun) nund++;
  end

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_vs();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask
  task automatic pulse_ld();
    @(negedge clk) line_done = 1'b1;
    @(negedge clk) line_done = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, u0, msz, nsz, nb, rows, per, idx, a0;
    rst_n = 1'b0; gain_en = 1'b0; ofs_en = 1'b0; vsync = 1'b0; line_done = 1'b0;
    size_m = '0; size_n = '0; img_w = '0; img_h = '0; gap = '0; auto_gnt = 1'b1;
    gain_base = GB; ofs_base = OB;
    tick(3);
    chk(req == 1'b0, "R1 req in reset", req, 0);
    chk(underrun == 1'b0, "R1 underrun in reset", underrun, 0);
    rst_n = 1'b1;
    tick(2);

    for (int v = 0; v < NV; v++) begin
      gain_en = 1'b0;
      tick(3);
      {size_m, size_n, img_w, img_h, ofs_en, gap} = VEC[v];
      msz  = 8 << ((size_m > 3'd4) ? 4 : int'(size_m));
      nsz  = 8 << ((size_n > 3'd4) ? 4 : int'(size_n));
      nb   = ((int'(img_w) + msz - 1) / msz + 7) / 8;
      rows = (int'(img_h) + nsz - 1) / nsz;
      per  = nb * (ofs_en ? 2 : 1);
      base = nlog; u0 = nund;
      gain_en = 1'b1;
      tick(150);
      chk(nlog - base == 2 * per, "R2 prefetch bursts", nlog - base, 2 * per);
      chk(lt[base+1] - lt[base] == int'(gap) + 1, "R9 grant spacing",
          lt[base+1] - lt[base], int'(gap) + 1);
      repeat (nsz) pulse_ld();
      tick(20);
      chk(nlog - base == 2 * per, "R6 line_done before vsync", nlog - base, 2 * per);
      pulse_vs();
      tick(60);
      for (int i = 0; i < int'(img_h); i++) begin
        pulse_ld();
        tick(60);
      end
      tick(100);
      chk(nlog - base == (rows + 3) * per, "R7 frame burst count", nlog - base, (rows + 3) * per);
      idx = base;
      for (int j = 0; j < rows + 3; j++) begin
        automatic int l = (j <= rows) ? j : j - rows - 1;
        for (int s = 0; s < (ofs_en ? 2 : 1); s++)
          for (int b = 0; b < nb; b++) begin
            automatic logic [31:0] ea = (s != 0 ? OB : GB) + 32'((l * nb + b) * 32);
            if (idx < nlog) begin
              chk(la[idx] == ea, "R3,R5 burst address", la[idx], ea);
              chk(lo[idx] == (s != 0), "R4 table select", lo[idx], s);
            end
            idx++;
          end
      end
      chk(nund == u0, "R10 no underrun when fetches keep up", nund - u0, 0);
    end

    gain_en = 1'b0;
    tick(3);
    {size_m, size_n, img_w, img_h, ofs_en, gap} = {3'd0, 3'd0, 14'd64, 14'd32, 1'b0, 13'd0};
    auto_gnt = 1'b0;
    gain_en = 1'b1;
    tick(5);
    chk(req == 1'b1, "R8 request pending", req, 1);
    chk(req_addr == GB, "R8 first address", req_addr, GB);
    a0 = int'(req_addr);
    tick(4);
    chk(req == 1'b1 && int'(req_addr) == a0, "R8 held without grant", req_addr, a0);
    u0 = nund;
    pulse_vs();
    tick(2);
    chk(nund - u0 == 1, "R10 underrun on stalled fetch", nund - u0, 1);
    gain_en = 1'b0;
    tick(1);
    chk(req == 1'b0, "R11 req drops when disabled", req, 0);
    u0 = nund; base = nlog; auto_gnt = 1'b1;
    pulse_vs();
    pulse_ld();
    tick(5);
    chk(req == 1'b0 && nlog == base, "R11 strobes ignored while disabled", nlog - base, 0);
    chk(nund == u0, "R11 no underrun while disabled", nund - u0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule